// File: doc/BRIEF.md
# Translation Buffer with Demap Command Engine

This block is a small fully associative address translation buffer. Each slot holds one fixed 8 KB page mapping, made of:

- a virtual page number,
- the partition and context identifiers it belongs to,
- a flag that marks the mapping as real rather than virtual,
- a pin (locked) bit,
- a recently-used bit,
- the physical page number.

A lookup compares the request against every slot in the same cycle. Hit, miss and the physical page appear on registered outputs one clock later. An insertion writes either a caller-chosen slot or a slot picked by the replacement rule. Before writing, it removes any existing mapping that carries the same tag.

Invalidation arrives as a memory-mapped demap write. The write address carries three things: the operation (one page, one context, or everything in the partition), the source of the context identifier, and, for page demaps, the page and the real flag. The current partition and the two context registers (primary and alternate) are plain inputs. A port-side input tells the decoder whether the write came from the data side or the instruction side; the two sides treat context source 1 differently.

A one-entry last-translation register remembers the slot of the previous hit. It reports reuse when the same slot hits again. Every demap write and every insertion request drops this register.

Top module: `tlb_dm_top`

## Requirements
- R1: One cycle after a cycle with `lkp_valid` high, the outputs report the lookup result. A slot matches when all of these agree with the request: it is valid, its page number equals `lkp_vpn`, its context equals `lkp_ctx`, its real flag equals `lkp_real`, and its partition equals `part_id`. On a match `lkp_hit`=1 and `lkp_ppn` is that slot's page. Otherwise `lkp_miss`=1 and `lkp_ppn`=0. After a cycle without a lookup, both flags and `lkp_ppn` are 0, as they are after reset.
- R2: `dmp_addr[7:6]` selects the demap operation: 0 = page, 1 = context, 2 = all. Value 3 is illegal. It sets `dmp_illegal` in the next cycle and changes no slot.
- R3: `dmp_addr[5:4]` selects the context source. 0 = `ctx_primary` and 3 = context 0. Value 2 marks the request ignored. Value 1 takes `ctx_secondary` when `dmp_side`=1 (data side) and marks the request ignored when `dmp_side`=0 (instruction side).
- R4: An ignored request performs no page demap and no context demap. An ignored demap-all still executes.
- R5: A page demap removes the slot whose page number equals `dmp_addr[63:13]`, whose real flag equals `dmp_addr[9]`, whose partition equals `part_id` and whose context equals the selected context. A slot differing only in the real flag stays.
- R6: A context demap removes every slot whose context equals the selected context and whose partition equals `part_id`, whatever its page or real flag.
- R7: A demap-all removes every unlocked slot of partition `part_id`. Locked slots and slots of other partitions stay.
- R8: An insertion first removes any valid slot with the same page, context, real flag and partition, so a later lookup returns the newly inserted page.
- R9: With `ins_use_slot`=1 the insertion writes slot `ins_slot`. Otherwise the slot is chosen in this order:
  - the lowest-index invalid slot;
  - if none, the lowest-index slot that is neither used nor locked;
  - if none, the highest-index slot.
- R10: An inserted slot gets its used bit set. If every used bit is then set, all of them are cleared except the new slot's. A removed slot loses its used bit.
- R11: `lkp_reuse`=1 together with a hit when the hit slot is the slot of the most recent earlier hit. Any demap write or insertion request in between prevents this, as does one in the same cycle as the lookup.
- R12: A lookup in the same cycle as a demap sees the slots after the demap. A lookup in the same cycle as an insertion sees the slots before it. An insertion requested in the same cycle as a demap write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| part_id | input | PART_W | Current partition |
| ctx_primary | input | CTX_W | Primary context register |
| ctx_secondary | input | CTX_W | Alternate context register (data side) |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VA_W-13 | Lookup virtual page number |
| lkp_ctx | input | CTX_W | Lookup context |
| lkp_real | input | 1 | Lookup is a real-address translation |
| ins_valid | input | 1 | Insertion request |
| ins_vpn | input | VA_W-13 | Inserted virtual page number |
| ins_ctx | input | CTX_W | Inserted context |
| ins_real | input | 1 | Inserted real flag |
| ins_locked | input | 1 | Inserted slot is locked |
| ins_ppn | input | PPN_W | Inserted physical page |
| ins_use_slot | input | 1 | Use `ins_slot` instead of the replacement rule |
| ins_slot | input | log2(ENTRIES) | Explicit slot index |
| dmp_valid | input | 1 | Demap write strobe |
| dmp_side | input | 1 | 1 = data side, 0 = instruction side |
| dmp_addr | input | VA_W | Demap write address (operation, context source, page, real flag) |
| lkp_hit | output | 1 | Registered hit |
| lkp_miss | output | 1 | Registered miss |
| lkp_ppn | output | PPN_W | Registered physical page of the hit |
| lkp_reuse | output | 1 | Hit served by the same slot as the previous hit |
| dmp_illegal | output | 1 | Previous demap write had operation 3 |

## Verification
The bench builds the block with ENTRIES=8, keeping the other widths at their defaults.

With eight slots, a handful of insertions fills the array. That puts three corner cases within a short run:
- the case where every used bit is set, which triggers the saturation clear;
- eviction of a valid slot chosen by the used/locked rule;
- the highest-index fallback when the other slots are locked.

The random phase draws pages, contexts and partitions from small pools. This makes overlapping insertions and demaps frequent: colliding tags, and context and partition demaps that hit several slots at once, alongside same-cycle combinations of lookup, insertion and demap.

// File: rtl/tlb_dm_pkg.sv
// Shared encodings for the translation buffer and its demap decoder.
// Assumes the demap field positions are fixed by the command format.
package tlb_dm_pkg;

    // Operation field of a demap write address (bits 7:6)
    typedef enum logic [1:0] {
        DM_PAGE = 2'd0,
        DM_CTX  = 2'd1,
        DM_ALL  = 2'd2,
        DM_BAD  = 2'd3
    } dm_op_e;

    // Context-source field of a demap write address (bits 5:4)
    typedef enum logic [1:0] {
        SRC_PRIMARY = 2'd0,
        SRC_ALT     = 2'd1,
        SRC_NONE    = 2'd2,
        SRC_ZERO    = 2'd3
    } dm_src_e;

endpackage

// File: rtl/tlb_dm_decode.sv
// Demap command decoder: turns a demap write address into one of the
// page / context / all invalidation strobes plus the match key.
// Assumes PAGE_SHIFT >= 11 so the real flag (bit 9) sits below the page.
module tlb_dm_decode
    import tlb_dm_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_W      = 13,
    localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
    input  logic             dmp_valid,
    input  logic             dmp_side,
    input  logic [VA_W-1:0]  dmp_addr,
    input  logic [CTX_W-1:0] ctx_primary,
    input  logic [CTX_W-1:0] ctx_secondary,
    output logic             do_page,
    output logic             do_ctx,
    output logic             do_all,
    output logic             bad,
    output logic [CTX_W-1:0] sel_ctx,
    output logic             sel_real,
    output logic [VPN_W-1:0] sel_vpn
);

    dm_op_e  op;
    dm_src_e src;
    logic    ignore;
    logic    unused_addr_bits;

    assign op               = dm_op_e'(dmp_addr[7:6]);
    assign src              = dm_src_e'(dmp_addr[5:4]);
    assign sel_vpn          = dmp_addr[VA_W-1:PAGE_SHIFT];
    assign sel_real         = dmp_addr[9];
    assign unused_addr_bits = ^{dmp_addr[PAGE_SHIFT-1:10], dmp_addr[8], dmp_addr[3:0]};

    // Pick the context the command refers to, or mark it ignored
    always_comb begin
        ignore  = 1'b0;
        sel_ctx = ctx_primary;
        case (src)
            SRC_PRIMARY: sel_ctx = ctx_primary;
            SRC_ALT: begin
                if (dmp_side) sel_ctx = ctx_secondary;
                else          ignore  = 1'b1;
            end
            SRC_NONE: ignore  = 1'b1;
            SRC_ZERO: sel_ctx = '0;
            default:  ignore  = 1'b1;
        endcase
    end

    // Convert the operation field into one-hot strobes
    always_comb begin
        do_page = dmp_valid && (op == DM_PAGE) && !ignore;
        do_ctx  = dmp_valid && (op == DM_CTX)  && !ignore;
        do_all  = dmp_valid && (op == DM_ALL);
        bad     = dmp_valid && (op == DM_BAD);
    end

endmodule

// File: rtl/tlb_dm_array.sv
// Fully associative slot array: per-slot tag compare for lookup, demap
// kill and insert-overlap, replacement choice and used-bit upkeep.
// Assumes ENTRIES is a power of two, at least 2, and that demap strobes
// and ins_fire never arrive together (the top drops the insert).
module tlb_dm_array #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 51,
    parameter int CTX_W   = 13,
    parameter int PART_W  = 8,
    parameter int PPN_W   = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PART_W-1:0] part_id,
    input  logic              do_page,
    input  logic              do_ctx,
    input  logic              do_all,
    input  logic [VPN_W-1:0]  sel_vpn,
    input  logic [CTX_W-1:0]  sel_ctx,
    input  logic              sel_real,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [CTX_W-1:0]  lkp_ctx,
    input  logic              lkp_real,
    input  logic              ins_fire,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [CTX_W-1:0]  ins_ctx,
    input  logic              ins_real,
    input  logic              ins_locked,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic              ins_use_slot,
    input  logic [IDX_W-1:0]  ins_slot,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PPN_W-1:0]  hit_ppn
);

    logic [ENTRIES-1:0] vld_q, used_q, lock_q, real_q;
    logic [ENTRIES-1:0] kill, lmatch, ovl, keep, used_k, used_n, tgt_oh;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [CTX_W-1:0]   ctx_q  [ENTRIES];
    logic [PART_W-1:0]  part_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic               free_hit, vict_hit;
    logic [IDX_W-1:0]   free_idx, vict_idx, tgt;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic own_part;
        assign own_part = vld_q[g] && (part_q[g] == part_id);

        // Demap kill: page, context or whole-partition match
        assign kill[g] = own_part && (
            (do_page && vpn_q[g] == sel_vpn && real_q[g] == sel_real && ctx_q[g] == sel_ctx) ||
            (do_ctx  && ctx_q[g] == sel_ctx) ||
            (do_all  && !lock_q[g]));

        // Lookup match against the post-demap state
        assign lmatch[g] = own_part && !kill[g] && vpn_q[g] == lkp_vpn &&
                           ctx_q[g] == lkp_ctx && real_q[g] == lkp_real;

        // Existing copy of the tag being inserted
        assign ovl[g] = ins_fire && own_part && vpn_q[g] == ins_vpn &&
                        ctx_q[g] == ins_ctx && real_q[g] == ins_real;

        // R7: an unlocked slot of the current partition is gone after demap-all
        a_r7_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (do_all && vld_q[g] && part_q[g] == part_id && !lock_q[g]) |=> !vld_q[g]);
        // R7: a locked slot survives demap-all
        a_r7_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (do_all && vld_q[g] && lock_q[g]) |=> vld_q[g]);
    end

    // Encode the (at most one) matching slot
    always_comb begin
        hit     = |lmatch;
        hit_idx = '0;
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lmatch[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
                hit_ppn = hit_ppn | ppn_q[i];
            end
        end
    end

    // Choose the insertion slot and the used bits that follow it
    always_comb begin
        keep     = vld_q & ~ovl;
        used_k   = used_q & ~ovl;
        free_hit = 1'b0;
        free_idx = '0;
        vict_hit = 1'b0;
        vict_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!keep[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (keep[i] && !used_k[i] && !lock_q[i]) begin
                vict_hit = 1'b1;
                vict_idx = IDX_W'(i);
            end
        end
        if (ins_use_slot) tgt = ins_slot;
        else if (free_hit) tgt = free_idx;
        else if (vict_hit) tgt = vict_idx;
        else               tgt = IDX_W'(ENTRIES - 1);
        tgt_oh      = '0;
        tgt_oh[tgt] = 1'b1;
        used_n      = used_k | tgt_oh;
        if (&used_n) used_n = tgt_oh;
    end

    // Status bits: demap clears, insert fills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            used_q <= '0;
            lock_q <= '0;
        end else if (|kill) begin
            vld_q  <= vld_q & ~kill;
            used_q <= used_q & ~kill;
        end else if (ins_fire) begin
            vld_q       <= keep | tgt_oh;
            used_q      <= used_n;
            lock_q[tgt] <= ins_locked;
        end
    end

    // Tag and payload storage, written only on insertion
    always_ff @(posedge clk) begin
        if (ins_fire) begin
            vpn_q[tgt]  <= ins_vpn;
            ctx_q[tgt]  <= ins_ctx;
            part_q[tgt] <= part_id;
            real_q[tgt] <= ins_real;
            ppn_q[tgt]  <= ins_ppn;
        end
    end

    // R8: overlap removal keeps tags unique, so at most one slot matches
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lmatch));
    // R10: a used bit is never left on an invalid slot
    a_r10_used_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((used_q & ~vld_q) == '0));
    // R10: after an insertion the used bits are never all set
    a_r10_no_saturation: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fire |=> !(&used_q));

endmodule

// File: rtl/tlb_dm_top.sv
// Translation buffer top: wires the demap decoder to the slot array,
// registers the lookup result and keeps the last-translation register.
// Assumes one request of each kind per cycle; a demap wins over an insert.
module tlb_dm_top #(
    parameter int ENTRIES    = 16,
    parameter int VA_W       = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_W      = 13,
    parameter int PART_W     = 8,
    parameter int PPN_W      = 28,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PART_W-1:0] part_id,
    input  logic [CTX_W-1:0]  ctx_primary,
    input  logic [CTX_W-1:0]  ctx_secondary,
    input  logic              lkp_valid,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [CTX_W-1:0]  lkp_ctx,
    input  logic              lkp_real,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [CTX_W-1:0]  ins_ctx,
    input  logic              ins_real,
    input  logic              ins_locked,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic              ins_use_slot,
    input  logic [IDX_W-1:0]  ins_slot,
    input  logic              dmp_valid,
    input  logic              dmp_side,
    input  logic [VA_W-1:0]   dmp_addr,
    output logic              lkp_hit,
    output logic              lkp_miss,
    output logic [PPN_W-1:0]  lkp_ppn,
    output logic              lkp_reuse,
    output logic              dmp_illegal
);

    logic             do_page, do_ctx, do_all, bad, sel_real, ins_fire;
    logic [CTX_W-1:0] sel_ctx;
    logic [VPN_W-1:0] sel_vpn;
    logic             hit, reuse_now, cache_vld_q;
    logic [IDX_W-1:0] hit_idx, cache_idx_q;
    logic [PPN_W-1:0] hit_ppn;

    assign ins_fire  = ins_valid && !dmp_valid;
    assign reuse_now = lkp_valid && hit && cache_vld_q && !dmp_valid &&
                       !ins_valid && (hit_idx == cache_idx_q);

    tlb_dm_decode #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .CTX_W(CTX_W)) u_dec (
        .dmp_valid(dmp_valid), .dmp_side(dmp_side), .dmp_addr(dmp_addr),
        .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
        .do_page(do_page), .do_ctx(do_ctx), .do_all(do_all), .bad(bad),
        .sel_ctx(sel_ctx), .sel_real(sel_real), .sel_vpn(sel_vpn)
    );

    tlb_dm_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W),
                   .PART_W(PART_W), .PPN_W(PPN_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .part_id(part_id),
        .do_page(do_page), .do_ctx(do_ctx), .do_all(do_all),
        .sel_vpn(sel_vpn), .sel_ctx(sel_ctx), .sel_real(sel_real),
        .lkp_vpn(lkp_vpn), .lkp_ctx(lkp_ctx), .lkp_real(lkp_real),
        .ins_fire(ins_fire), .ins_vpn(ins_vpn), .ins_ctx(ins_ctx),
        .ins_real(ins_real), .ins_locked(ins_locked), .ins_ppn(ins_ppn),
        .ins_use_slot(ins_use_slot), .ins_slot(ins_slot),
        .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn)
    );

    // Register the lookup result and the illegal-command flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lkp_hit     <= 1'b0;
            lkp_miss    <= 1'b0;
            lkp_ppn     <= '0;
            lkp_reuse   <= 1'b0;
            dmp_illegal <= 1'b0;
        end else begin
            lkp_hit     <= lkp_valid && hit;
            lkp_miss    <= lkp_valid && !hit;
            lkp_ppn     <= (lkp_valid && hit) ? hit_ppn : '0;
            lkp_reuse   <= reuse_now;
            dmp_illegal <= bad;
        end
    end

    // Last-translation register: dropped by any demap or insert request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_vld_q <= 1'b0;
            cache_idx_q <= '0;
        end else if (dmp_valid || ins_valid) begin
            cache_vld_q <= 1'b0;
        end else if (lkp_valid && hit) begin
            cache_vld_q <= 1'b1;
            cache_idx_q <= hit_idx;
        end
    end

    // R1: hit and miss are never reported together
    a_r1_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_hit && lkp_miss));
    // R2: operation value 3 raises the illegal flag next cycle
    a_r2_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dmp_valid && dmp_addr[7:6] == 2'b11) |=> dmp_illegal);
    // R11: reuse is only ever reported with a hit
    a_r11_reuse_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_reuse |-> lkp_hit);
    // R11: a demap write forbids reuse on the lookup beside it
    a_r11_demap_no_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        dmp_valid |=> !lkp_reuse);

endmodule

// File: tb/tlb_dm_top_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural slot model is advanced every cycle
// and the registered outputs are compared one cycle after each request.
module tlb_dm_top_tb_top;

    localparam int ENT   = 8;
    localparam int VA    = 64;
    localparam int CTXW  = 13;
    localparam int PARTW = 8;
    localparam int PPNW  = 28;
    localparam int VPNW  = VA - 13;
    localparam int IDXW  = $clog2(ENT);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PARTW-1:0] part_id = 8'h05;
    logic [CTXW-1:0]  ctx_primary = 13'h11, ctx_secondary = 13'h22;
    logic             lkp_valid, lkp_real, ins_valid, ins_real, ins_locked, ins_use_slot;
    logic [VPNW-1:0]  lkp_vpn, ins_vpn;
    logic [CTXW-1:0]  lkp_ctx, ins_ctx;
    logic [PPNW-1:0]  ins_ppn;
    logic [IDXW-1:0]  ins_slot;
    logic             dmp_valid, dmp_side;
    logic [VA-1:0]    dmp_addr;
    logic             lkp_hit, lkp_miss, lkp_reuse, dmp_illegal;
    logic [PPNW-1:0]  lkp_ppn;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    // reference model state
    bit             m_vld [ENT], m_used [ENT], m_lock [ENT], m_real [ENT];
    bit [VPNW-1:0]  m_vpn [ENT];
    bit [CTXW-1:0]  m_ctx [ENT];
    bit [PARTW-1:0] m_part [ENT];
    bit [PPNW-1:0]  m_ppn [ENT];
    bit             m_cv = 1'b0;
    int             m_ci = 0;

    always #2 clk = ~clk;

    tlb_dm_top #(.ENTRIES(ENT), .VA_W(VA), .CTX_W(CTXW), .PART_W(PARTW), .PPN_W(PPNW)) dut_i (
        .clk(clk), .rst_n(rst_n), .part_id(part_id),
        .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_ctx(lkp_ctx), .lkp_real(lkp_real),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ctx(ins_ctx), .ins_real(ins_real),
        .ins_locked(ins_locked), .ins_ppn(ins_ppn), .ins_use_slot(ins_use_slot),
        .ins_slot(ins_slot), .dmp_valid(dmp_valid), .dmp_side(dmp_side),
        .dmp_addr(dmp_addr), .lkp_hit(lkp_hit), .lkp_miss(lkp_miss),
        .lkp_ppn(lkp_ppn), .lkp_reuse(lkp_reuse), .dmp_illegal(dmp_illegal)
    );

    task automatic clr();
        lkp_valid = 0; lkp_vpn = '0; lkp_ctx = '0; lkp_real = 0;
        ins_valid = 0; ins_vpn = '0; ins_ctx = '0; ins_real = 0; ins_locked = 0;
        ins_ppn = '0; ins_use_slot = 0; ins_slot = '0;
        dmp_valid = 0; dmp_side = 0; dmp_addr = '0;
    endtask

    task automatic set_lkp(input logic [VPNW-1:0] v, input logic [CTXW-1:0] c, input logic r);
        lkp_valid = 1; lkp_vpn = v; lkp_ctx = c; lkp_real = r;
    endtask

    task automatic set_ins(input logic [VPNW-1:0] v, input logic [CTXW-1:0] c, input logic r,
                           input logic lk, input logic [PPNW-1:0] p, input logic us,
                           input logic [IDXW-1:0] s);
        ins_valid = 1; ins_vpn = v; ins_ctx = c; ins_real = r; ins_locked = lk;
        ins_ppn = p; ins_use_slot = us; ins_slot = s;
    endtask

    // demap address: page in 63:13, real flag bit 9, op 7:6, context source 5:4
    task automatic set_dmp(input logic side, input logic [VPNW-1:0] v, input logic r,
                           input logic [1:0] op, input logic [1:0] src);
        dmp_valid = 1; dmp_side = side;
        dmp_addr = {v, 13'b0};
        dmp_addr[9] = r; dmp_addr[7:6] = op; dmp_addr[5:4] = src;
    endtask

    // advance model by one request set, clock the DUT, compare outputs
    task automatic step(input string tag);
        bit e_hit = 0, e_miss = 0, e_reuse = 0, e_ill = 0, ign, k, all_u;
        bit [PPNW-1:0] e_ppn = '0;
        bit [CTXW-1:0] sc;
        int op, src, hidx = -1, slot;
        if (dmp_valid) begin
            op = int'(dmp_addr[7:6]); src = int'(dmp_addr[5:4]);
            ign = 0; sc = ctx_primary;
            if (src == 1) begin if (dmp_side) sc = ctx_secondary; else ign = 1; end
            else if (src == 2) ign = 1;
            else if (src == 3) sc = '0;
            e_ill = (op == 3);
            for (int e = 0; e < ENT; e++) begin
                k = 0;
                if (m_vld[e] && m_part[e] == part_id) begin
                    if (op == 0 && !ign && m_vpn[e] == dmp_addr[63:13] &&
                        m_real[e] == dmp_addr[9] && m_ctx[e] == sc) k = 1;
                    if (op == 1 && !ign && m_ctx[e] == sc) k = 1;
                    if (op == 2 && !m_lock[e]) k = 1;
                end
                if (k) begin m_vld[e] = 0; m_used[e] = 0; end
            end
        end
        if (lkp_valid) begin
            for (int e = 0; e < ENT; e++)
                if (m_vld[e] && m_part[e] == part_id && m_vpn[e] == lkp_vpn &&
                    m_ctx[e] == lkp_ctx && m_real[e] == lkp_real) hidx = e;
            if (hidx >= 0) begin
                e_hit = 1; e_ppn = m_ppn[hidx];
                e_reuse = m_cv && !dmp_valid && !ins_valid && (m_ci == hidx);
            end else e_miss = 1;
        end
        if (dmp_valid || ins_valid) m_cv = 0;
        else if (hidx >= 0) begin m_cv = 1; m_ci = hidx; end
        if (ins_valid && !dmp_valid) begin
            for (int e = 0; e < ENT; e++)
                if (m_vld[e] && m_part[e] == part_id && m_vpn[e] == ins_vpn &&
                    m_ctx[e] == ins_ctx && m_real[e] == ins_real) begin
                    m_vld[e] = 0; m_used[e] = 0;
                end
            slot = -1;
            if (ins_use_slot) slot = int'(ins_slot);
            for (int e = 0; e < ENT; e++) if (slot < 0 && !m_vld[e]) slot = e;
            for (int e = 0; e < ENT; e++) if (slot < 0 && !m_used[e] && !m_lock[e]) slot = e;
            if (slot < 0) slot = ENT - 1;
            m_vld[slot] = 1; m_used[slot] = 1; m_lock[slot] = ins_locked;
            m_vpn[slot] = ins_vpn; m_ctx[slot] = ins_ctx; m_real[slot] = ins_real;
            m_part[slot] = part_id; m_ppn[slot] = ins_ppn;
            all_u = 1;
            for (int e = 0; e < ENT; e++) if (!m_used[e]) all_u = 0;
            if (all_u) for (int e = 0; e < ENT; e++) m_used[e] = (e == slot);
        end
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({lkp_hit, lkp_miss, lkp_ppn, lkp_reuse, dmp_illegal} !==
            {e_hit, e_miss, e_ppn, e_reuse, e_ill}) begin
            n_err++;
            $display("FAIL %s: hit/miss/ppn/reuse/illegal got %0b/%0b/%h/%0b/%0b expected %0b/%0b/%h/%0b/%0b",
                     tag, lkp_hit, lkp_miss, lkp_ppn, lkp_reuse, dmp_illegal,
                     e_hit, e_miss, e_ppn, e_reuse, e_ill);
        end
        clr();
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({lkp_hit, lkp_miss, lkp_ppn, lkp_reuse, dmp_illegal} !== '0) begin
            n_err++;
            $display("FAIL R1 reset: got %b expected 0",
                     {lkp_hit, lkp_miss, lkp_ppn, lkp_reuse, dmp_illegal});
        end
        rst_n = 1;
        step("R1 idle after reset");

        // fill and basic lookups
        set_ins(51'h12345, 13'h11, 0, 0, 28'h100, 0, 0); step("R9 lowest free slot");
        set_ins(51'h22222, 13'h22, 0, 0, 28'h200, 0, 0); step("R9 next free slot");
        set_ins(51'h00003, 13'h00, 0, 1, 28'h300, 0, 0); step("R9 locked insert");
        set_ins(51'h12345, 13'h11, 1, 0, 28'h400, 0, 0); step("R8 real twin is distinct");
        set_lkp(51'h12345, 13'h11, 0); step("R1 hit virtual A");
        set_lkp(51'h12345, 13'h11, 0); step("R11 reuse same slot");
        set_lkp(51'h12345, 13'h11, 1); step("R1 hit real twin");
        set_lkp(51'h12345, 13'h12, 0); step("R1 context mismatch miss");
        part_id = 8'h06; set_lkp(51'h12345, 13'h11, 0); step("R1 partition mismatch miss");
        part_id = 8'h05;
        set_lkp(51'h22222, 13'h22, 0); step("R1 hit B");
        set_lkp(51'h22222, 13'h22, 0); step("R11 reuse B");
        set_dmp(1, 51'h12345, 0, 2'd3, 2'd0); step("R2 illegal op flag");
        set_lkp(51'h22222, 13'h22, 0); step("R11 demap drops cache; R2 no change");
        set_lkp(51'h12345, 13'h11, 0); step("R2 illegal op kept A");
        step("R1 idle outputs low");

        // page demap and same-cycle lookup
        set_dmp(1, 51'h12345, 0, 2'd0, 2'd0); step("R5 page demap primary");
        set_lkp(51'h12345, 13'h11, 0); step("R5 page removed");
        set_lkp(51'h12345, 13'h11, 1); step("R5 real twin kept");
        set_dmp(1, 51'h12345, 1, 2'd0, 2'd0); set_lkp(51'h12345, 13'h11, 1);
        step("R12 lookup sees demap");

        // context sources and ignore
        set_dmp(1, 51'h22222, 0, 2'd0, 2'd1); step("R3 data side alternate context");
        set_lkp(51'h22222, 13'h22, 0); step("R3 alternate context removed B");
        set_ins(51'h22222, 13'h22, 0, 0, 28'h201, 0, 0); step("R9 reinsert B");
        set_dmp(0, 51'h22222, 0, 2'd0, 2'd1); step("R3 instruction side ignore");
        set_lkp(51'h22222, 13'h22, 0); step("R3 ignored demap kept B");
        set_dmp(1, 51'h22222, 0, 2'd1, 2'd2); step("R4 ignored context demap");
        set_lkp(51'h22222, 13'h22, 0); step("R4 B survives ignored demap");
        set_dmp(1, 51'h00003, 0, 2'd0, 2'd3); step("R3 context zero page demap");
        set_lkp(51'h00003, 13'h00, 0); step("R3 context zero removed C");

        // context demap
        set_ins(51'h12345, 13'h11, 0, 0, 28'h110, 0, 0); step("R6 setup");
        set_ins(51'h00044, 13'h11, 1, 0, 28'h111, 0, 0); step("R6 setup");
        set_ins(51'h00055, 13'h22, 0, 0, 28'h222, 0, 0); step("R6 setup");
        set_dmp(1, 51'h0, 0, 2'd1, 2'd0); step("R6 context demap");
        set_lkp(51'h12345, 13'h11, 0); step("R6 ctx entry gone");
        set_lkp(51'h00044, 13'h11, 1); step("R6 ctx real entry gone");
        set_lkp(51'h00055, 13'h22, 0); step("R6 other ctx kept");

        // demap all
        set_ins(51'h00003, 13'h00, 0, 1, 28'h301, 0, 0); step("R7 setup locked");
        part_id = 8'h06;
        set_ins(51'h00066, 13'h11, 0, 0, 28'h600, 0, 0); step("R7 setup other partition");
        part_id = 8'h05;
        set_dmp(0, 51'h0, 0, 2'd2, 2'd2); step("R4 demap-all despite ignore");
        set_lkp(51'h00003, 13'h00, 0); step("R7 locked kept");
        set_lkp(51'h22222, 13'h22, 0); step("R7 unlocked removed");
        part_id = 8'h06; set_lkp(51'h00066, 13'h11, 0); step("R7 other partition kept");
        part_id = 8'h05;

        // overlap, same-cycle rules, explicit slot
        set_ins(51'h00077, 13'h11, 0, 0, 28'h010, 0, 0); step("R8 first copy");
        set_ins(51'h00077, 13'h11, 0, 0, 28'h020, 0, 0); step("R8 second copy");
        set_lkp(51'h00077, 13'h11, 0); step("R8 newest page returned");
        set_ins(51'h00088, 13'h11, 0, 0, 28'h080, 0, 0); set_dmp(1, 51'h1, 0, 2'd0, 2'd0);
        step("R12 insert dropped by demap");
        set_lkp(51'h00088, 13'h11, 0); step("R12 dropped insert misses");
        set_ins(51'h00088, 13'h11, 0, 0, 28'h081, 0, 0); set_lkp(51'h00088, 13'h11, 0);
        step("R12 lookup sees pre-insert");
        set_lkp(51'h00088, 13'h11, 0); step("R12 insert visible next");
        set_ins(51'h00099, 13'h11, 0, 0, 28'h099, 1, 3'd0); step("R9 explicit slot");
        set_lkp(51'h00099, 13'h11, 0); step("R9 explicit slot hit");

        // saturation and eviction
        for (int i = 0; i < 14; i++) begin
            set_ins(51'h100 + VPNW'(i), 13'h11, 0, (i == 5), PPNW'(28'h700 + i), 0, 0);
            step("R10 fill and evict");
        end
        for (int i = 0; i < 14; i++) begin
            set_lkp(51'h100 + VPNW'(i), 13'h11, 0); step("R10 survivors after eviction");
        end

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            part_id = ($urandom_range(0, 3) == 0) ? 8'h06 : 8'h05;
            if ($urandom_range(0, 1) == 1)
                set_lkp(VPNW'($urandom_range(0, 5)), CTXW'($urandom_range(0, 2) * 17), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 2) == 0)
                set_ins(VPNW'($urandom_range(0, 5)), CTXW'($urandom_range(0, 2) * 17),
                        1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                        PPNW'($urandom), ($urandom_range(0, 5) == 0), IDXW'($urandom_range(0, ENT - 1)));
            if ($urandom_range(0, 7) == 0)
                set_dmp(1'($urandom_range(0, 1)), VPNW'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
                        2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            step("R1/R9/R10/R12 random mix");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule